// File: doc/BRIEF.md
# Maskable interrupt priority and acknowledge unit

This block takes eight active-high interrupt request lines and decides which one the processor should service next. It keeps a request register (pending levels) and an in-service register (levels the processor has accepted and not yet closed). Each level can be blocked by its own bit in a mask word. Fixed priority applies: level 0 is the most urgent and level 7 the least.

The block raises its interrupt output when an unmasked pending request outranks every level that is in service. The processor answers with two low pulses on an active-low acknowledge line. The first pulse moves the winning level from the request register into the in-service register. The second pulse presents an 8-bit vector made of the upper five bits of a programmed base followed by the 3-bit level. An end-of-interrupt strobe closes the most urgent in-service level.

The trigger mode, the mask and the vector base come from a separate command sequencer. This block only reads them.

Top module: `irq_prio_ack`

## Requirements
- R1: While `rst_n` is low and on the first cycle after reset, `irr_o` and `isr_o` read 0, and `irq_o` and `vec_valid_o` are low.
- R2: `irq_o` is high exactly when the lowest-numbered pending unmasked level (`irr_o & ~mask_i`) has a lower index than every set bit of `isr_o`, or when `isr_o` is zero and such a level exists. Index 0 is the highest priority.
- R3: A mask bit of 1 keeps its level from raising `irq_o` and from being acknowledged. The level's request bit is not cleared; it stays visible on `irr_o`.
- R4: With `edge_mode_i` = 1, a request bit is set when its input is sampled 0 on one clock edge and 1 on the next. The bit is held until that level is acknowledged. An input that stays high after the acknowledge does not set the bit again; the input must return low first.
- R5: With `edge_mode_i` = 0, each request bit equals the input sampled on the previous clock edge. The exception is the acknowledged level, which reads 0 for one cycle.
- R6: The first acknowledge pulse is a clock edge that samples `ack_n_i` low after an edge that sampled it high. On the cycle after it, the winning level per R2 reads 1 in `isr_o` and 0 in `irr_o`. If no level wins, neither register changes and level 7 is recorded for the vector.
- R7: The second falling sample of `ack_n_i` loads `vec_o` with `{vec_base_i[7:3], level}`. From the next cycle, `vec_valid_o` stays high until the cycle after `ack_n_i` is sampled high. `vec_valid_o` is never high unless `ack_n_i` was low at the previous edge.
- R8: A one-cycle `eoi_i` pulse clears the lowest-numbered set bit of `isr_o` on the next cycle. It has no effect when `isr_o` is zero.
- R9: When `eoi_i` and a first acknowledge pulse fall on the same edge, the winner is judged against the old `isr_o`. The end-of-interrupt clears the old most urgent in-service bit, and the new winner's bit is set in the same update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Interrupt request lines, active high |
| edge_mode_i | input | 1 | 1 selects rising-edge capture, 0 selects level capture |
| mask_i | input | 8 | Per-level mask, 1 blocks that level |
| vec_base_i | input | 8 | Vector base; its upper five bits are used |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| ack_n_i | input | 1 | Acknowledge from the processor, active low |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector for the acknowledged level |
| vec_valid_o | output | 1 | `vec_o` is being presented |
| irr_o | output | 8 | Pending request register |
| isr_o | output | 8 | In-service register |

## Verification
Two functions can act on the in-service register in the same cycle: an end-of-interrupt clearing the old most urgent bit, and a first acknowledge pulse setting the new winner's bit. A directed case provokes this collision. Level 3 is placed in service, a higher-priority level 1 is raised, and then `eoi_i` and the falling `ack_n_i` are driven together. The result must show only level 1 in service, and the vector that follows must carry level 1. The random phase drives both strobes independently, so they also meet by chance. A bench model, written from the requirements, predicts every register bit and output each cycle and judges those random collisions as well.

// File: rtl/irq_prio_ack.sv
module irq_prio_ack #(
  parameter int N  = 8,
  parameter int VW = 8,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          edge_mode_i,
  input  logic [N-1:0]  mask_i,
  input  logic [VW-1:0] vec_base_i,
  input  logic          eoi_i,
  input  logic          ack_n_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o,
  output logic          vec_valid_o,
  output logic [N-1:0]  irr_o,
  output logic [N-1:0]  isr_o
);

  function automatic logic [LW-1:0] lowest(input logic [N-1:0] v);
    lowest = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) lowest = LW'(i);
  endfunction

  logic [N-1:0]  irr_q, isr_q, req_q;
  logic          ack_q, second_q, vv_q;
  logic [LW-1:0] lvl_q;
  logic [VW-1:0] vec_q;

  logic [N-1:0]  elig;
  logic [LW-1:0] req_idx, isr_idx;
  logic          win, fall, take;
  logic [N-1:0]  take_mask, eoi_mask, rise;

  assign elig      = irr_q & ~mask_i;
  assign req_idx   = lowest(elig);
  assign isr_idx   = lowest(isr_q);
  assign win       = (|elig) && (~|isr_q || req_idx < isr_idx);
  assign fall      = ack_q & ~ack_n_i;
  assign take      = fall & ~second_q & win;
  assign take_mask = take ? (N'(1) << req_idx) : '0;
  assign eoi_mask  = (eoi_i && |isr_q) ? (N'(1) << isr_idx) : '0;
  assign rise      = req_i & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q    <= '0;
      isr_q    <= '0;
      req_q    <= '0;
      ack_q    <= 1'b1;
      second_q <= 1'b0;
      vv_q     <= 1'b0;
      lvl_q    <= '0;
      vec_q    <= '0;
    end else begin
      req_q <= req_i;
      ack_q <= ack_n_i;
      irr_q <= (edge_mode_i ? (irr_q | rise) : req_i) & ~take_mask;
      isr_q <= (isr_q & ~eoi_mask) | take_mask;
      if (fall) begin
        second_q <= ~second_q;
        if (!second_q) begin
          lvl_q <= win ? req_idx : LW'(N - 1);
        end else begin
          vec_q <= {vec_base_i[VW-1:LW], lvl_q};
          vv_q  <= 1'b1;
        end
      end else if (ack_n_i) begin
        vv_q <= 1'b0;
      end
    end
  end

  assign irq_o       = win;
  assign vec_o       = vec_q;
  assign vec_valid_o = vv_q;
  assign irr_o       = irr_q;
  assign isr_o       = isr_q;

endmodule

// File: rtl/irq_prio_ack_chk.sv
module irq_prio_ack_chk #(
  parameter int N = 8,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          edge_mode_i,
  input logic [N-1:0]  mask_i,
  input logic          eoi_i,
  input logic          ack_n_i,
  input logic          irq_o,
  input logic          vec_valid_o,
  input logic [N-1:0]  irr_o,
  input logic [N-1:0]  isr_o
);

  logic [N-1:0] isr_low, above_isr;
  assign isr_low   = isr_o & (~isr_o + N'(1));
  assign above_isr = isr_low - N'(1);

  p_irq_outranks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((irr_o & ~mask_i & above_isr) != '0));

  p_masked_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode_i |=> ((irr_o & $past(irr_o & mask_i)) == $past(irr_o & mask_i)));

  p_isr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr_o) <= $countones($past(isr_o)) + 1);

  p_vec_in_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> !$past(ack_n_i));

  p_eoi_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && ack_n_i && isr_o != '0) |=> $countones(isr_o) == $countones($past(isr_o)) - 1);

endmodule

bind irq_prio_ack irq_prio_ack_chk #(.N(N), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_mode_i(edge_mode_i), .mask_i(mask_i),
  .eoi_i(eoi_i), .ack_n_i(ack_n_i), .irq_o(irq_o), .vec_valid_o(vec_valid_o),
  .irr_o(irr_o), .isr_o(isr_o)
);

// File: tb/irq_prio_ack_tb.sv
`timescale 1ns/1ps
module irq_prio_ack_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] req = 0, mask = 0, base = 8'h40;
  logic edge_m = 1, eoi = 0, ack_n = 1;
  logic irq, vv;
  logic [7:0] vec, irr, isr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_ack u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .edge_mode_i(edge_m), .mask_i(mask),
    .vec_base_i(base), .eoi_i(eoi), .ack_n_i(ack_n), .irq_o(irq), .vec_o(vec),
    .vec_valid_o(vv), .irr_o(irr), .isr_o(isr)
  );

  // reference model built from the requirements
  logic [7:0] m_irr, m_isr, m_reqq, m_vec;
  logic m_ackq, m_second, m_vv;
  logic [2:0] m_lvl;

  function automatic logic [7:0] lowbit(input logic [7:0] v);
    return v & (~v + 8'd1);
  endfunction

  function automatic logic [7:0] m_cand(input logic [7:0] irr_v, isr_v, msk);
    logic [7:0] above;
    above = lowbit(isr_v) - 8'd1;
    return lowbit(irr_v & ~msk) & above;
  endfunction

  function automatic logic [2:0] idx(input logic [7:0] oh);
    for (int i = 0; i < 8; i++) if (oh[i]) return 3'(i);
    return 3'd7;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] c, clr, nirr;
    logic f;
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_reqq = 0; m_vec = 0;
      m_ackq = 1; m_second = 0; m_vv = 0; m_lvl = 0;
    end else begin
      c   = m_cand(m_irr, m_isr, mask);
      f   = m_ackq && !ack_n;
      clr = (f && !m_second) ? c : 8'h00;
      nirr = edge_m ? ((m_irr | (req & ~m_reqq)) & ~clr) : (req & ~clr);
      m_isr = (eoi ? (m_isr & ~lowbit(m_isr)) : m_isr) | clr;
      m_irr = nirr;
      if (f) begin
        if (!m_second) m_lvl = (c != 0) ? idx(c) : 3'd7;
        else begin m_vec = {base[7:3], m_lvl}; m_vv = 1; end
        m_second = !m_second;
      end else if (ack_n) m_vv = 0;
      m_reqq = req;
      m_ackq = ack_n;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc_n = 0;
    while (!done && cyc_n < 100000) begin @(posedge clk); cyc_n++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    cyc(2);
    chk("R1 irr", irr, 0); chk("R1 isr", isr, 0);
    chk("R1 irq", {7'd0, irq}, 0); chk("R1 vv", {7'd0, vv}, 0);
    rst_n = 1;
    cyc(1);
    chk("R1 irr after release", irr, 0); chk("R1 irq after release", {7'd0, irq}, 0);
    // edge capture of level 3
    req = 8'h08; cyc(1);
    chk("R4 irr set on rise", irr, 8'h08); chk("R2 irq", {7'd0, irq}, 1);
    mask = 8'h08; #1;
    chk("R3 masked irq", {7'd0, irq}, 0); chk("R3 masked irr kept", irr, 8'h08);
    cyc(2);
    chk("R3 masked irr still kept", irr, 8'h08);
    mask = 0;
    // first pulse
    ack_n = 0; cyc(1);
    chk("R6 isr set", isr, 8'h08); chk("R6 irr cleared", irr, 0);
    chk("R2 irq low under service", {7'd0, irq}, 0);
    ack_n = 1; cyc(1);
    ack_n = 0; cyc(1);
    chk("R7 vv", {7'd0, vv}, 1); chk("R7 vec", vec, 8'h43);
    ack_n = 1; cyc(1);
    chk("R7 vv drop", {7'd0, vv}, 0);
    cyc(2);
    chk("R4 no re-arm while held", irr, 0);
    // higher-priority level 1 and collision of EOI with first pulse
    req = 8'h0A; cyc(1);
    chk("R4 level1 set", irr, 8'h02); chk("R2 higher prio irq", {7'd0, irq}, 1);
    eoi = 1; ack_n = 0; cyc(1);
    chk("R9 isr after eoi+ack", isr, 8'h02); chk("R9 irr", irr, 0);
    eoi = 0; ack_n = 1; base = 8'hA8; cyc(1);
    ack_n = 0; cyc(1);
    chk("R9 vec level1", vec, 8'hA9); chk("R7 vv again", {7'd0, vv}, 1);
    ack_n = 1; cyc(1);
    eoi = 1; cyc(1);
    eoi = 0; chk("R8 eoi clears", isr, 0);
    eoi = 1; cyc(1);
    eoi = 0; chk("R8 eoi on empty", isr, 0);
    // spurious acknowledge: no winner
    req = 0; cyc(1);
    ack_n = 0; cyc(1); ack_n = 1; cyc(1); ack_n = 0; cyc(1);
    chk("R6 spurious isr", isr, 0); chk("R6 spurious vec level 7", vec, 8'hAF);
    ack_n = 1; cyc(1);
    // level mode
    edge_m = 0; req = 8'h80; cyc(1);
    chk("R5 level follows high", irr, 8'h80);
    req = 8'h00; cyc(1);
    chk("R5 level follows low", irr, 8'h00);
    // random phase against model
    for (int k = 0; k < 4000; k++) begin
      chk("R4/R5 irr model", irr, m_irr);
      chk("R6/R8/R9 isr model", isr, m_isr);
      chk("R2/R3 irq model", {7'd0, irq}, {7'd0, (m_cand(m_irr, m_isr, mask) != 0)});
      chk("R7 vv model", {7'd0, vv}, {7'd0, m_vv});
      if (m_vv) chk("R7 vec model", vec, m_vec);
      if ($urandom_range(3) == 0) req = req ^ 8'($urandom);
      if ($urandom_range(31) == 0) mask = 8'($urandom) & 8'($urandom);
      if ($urandom_range(199) == 0) edge_m = ~edge_m;
      if ($urandom_range(15) == 0) base = 8'($urandom);
      eoi = ($urandom_range(11) == 0);
      if ($urandom_range(3) == 0) ack_n = ~ack_n;
      cyc(1);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule